// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. A shared free-running up-counter, kept outside the block, is presented on `count_i`. The channel holds a 64-bit configuration word, a 64-bit comparator and a 64-bit period. Writes to these registers arrive as 32-bit words with one strobe per half. When the counter equals the comparator, the channel emits a one-cycle `fire_o` pulse toward the interrupt logic.

In one-shot mode the comparator stays where software placed it. In periodic mode the comparator moves itself forward by the period after every match. If the counter has already run past the new value, the comparator keeps adding the period, one addition per clock, until it lies strictly ahead of the counter again.

A forced narrow mode works on the low 32 bits only. In that mode the comparisons, the additions and the stored values are all truncated to 32 bits.

In periodic mode a comparator write normally loads the period and leaves the comparator alone. An arm bit in the configuration lets the next write load the comparator directly. That arm bit clears itself after one write to either half of the comparator.

Top module: `evtc_channel`

## Requirements
- R1: After reset the configuration reads back as follows. The upper half is the `ROUTE_CAP` parameter. The low half is 0x30: bit 4 is periodic-capable and bit 5 is wide-capable. The comparator reads all ones, the period reads zero and `fire_o` is low.
- R2: A write to the upper configuration half changes nothing. A write to the low half alters only these bits: bit 2 (channel enable), bit 3 (periodic), bit 6 (set-value arm) and bit 8 (narrow mode). All other bits keep their value.
- R3: When narrow mode (bit 8) is set, a comparator write keeps only the low 32 bits, and the comparator's upper half stays zero.
- R4: A comparator write changes the comparator only in one-shot mode (bit 3 clear) or when bit 6 is set. In periodic mode without bit 6, the comparator is left unchanged.
- R5: In periodic mode a low-half write is copied into the period's low half. In narrow mode bit 31 of that copy is cleared. Without bit 6, a high-half write goes into the period's upper half with bit 63 cleared.
- R6: Bit 6 reads zero after any write to either comparator half.
- R7: A configuration write that sets bit 8 truncates the stored comparator and period to their low 32 bits.
- R8: The channel is active when bit 2 is set and `glb_en_i` is high. While active, a counter equal to the comparator (in the active width) raises `fire_o` for exactly one cycle, in the cycle after the clock edge that sees the match. The counter holding still does not repeat the pulse.
- R9: In periodic mode with a nonzero period, a match adds the period to the comparator. The addition repeats on each following clock until the wrapped difference (comparator minus counter) is positive. In narrow mode this difference and the sum are computed at 32 bits.
- R10: Two cases produce no pulse and no comparator advance. The first is a configuration write clearing bit 2 in the same cycle as a match. The second is a match while `glb_en_i` is low.
- R11: In periodic mode with a zero period, a match fires once and the comparator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en_i | input | 1 | Global enable shared by all channels |
| count_i | input | 64 | Current value of the shared up-counter |
| wdata_i | input | 32 | Write data for whichever half is strobed |
| cfg_lo_we_i | input | 1 | Write strobe, low configuration half |
| cfg_hi_we_i | input | 1 | Write strobe, upper configuration half (no effect) |
| cmp_lo_we_i | input | 1 | Write strobe, low comparator half |
| cmp_hi_we_i | input | 1 | Write strobe, upper comparator half |
| fire_o | output | 1 | One-cycle event pulse |
| cfg_o | output | 64 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |
| period_o | output | 64 | Period readback |

## Verification
The bench builds the channel with the default 32-bit half width and a non-default `ROUTE_CAP` of 0x00A50003. This value makes the read-only upper configuration half distinguishable from zero, from all ones and from any writable bit.

Because the counter is a plain input, the bench can place it anywhere directly, without counting up to it. It can set a value just below the 32-bit wrap with a nonzero upper word, which shows that narrow-mode matching ignores the upper bits. It can also step the counter well past a freshly advanced comparator to force several catch-up additions.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int HW     = 32;
  localparam int CW     = 2 * HW;
  localparam int B_EN   = 2;
  localparam int B_PER  = 3;
  localparam int B_PCAP = 4;
  localparam int B_WCAP = 5;
  localparam int B_SETV = 6;
  localparam int B_M32  = 8;

  // wrapped difference cmp - cnt strictly positive in the active width
  function automatic logic ahead_f(input logic [CW-1:0] cmp,
                                   input logic [CW-1:0] cnt,
                                   input logic          m32);
    logic [CW-1:0] d;
    d = cmp - cnt;
    if (m32) return !d[HW-1] && (d[HW-1:0] != '0);
    return !d[CW-1] && (d != '0);
  endfunction

  // comparator plus period, wrapping at 32 bits in narrow mode
  function automatic logic [CW-1:0] step_f(input logic [CW-1:0] cmp,
                                           input logic [CW-1:0] per,
                                           input logic          m32);
    logic [CW-1:0] s;
    s = cmp + per;
    if (m32) return {{HW{1'b0}}, s[HW-1:0]};
    return s;
  endfunction

  // equality in the active width
  function automatic logic eq_f(input logic [CW-1:0] a,
                                input logic [CW-1:0] b,
                                input logic          m32);
    if (m32) return a[HW-1:0] == b[HW-1:0];
    return a == b;
  endfunction
endpackage

// File: rtl/evtc_cfg.sv
module evtc_cfg
  import evtc_pkg::*;
#(
  parameter logic [HW-1:0] ROUTE_CAP = 32'h0000_0F00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_lo_we,
  input  logic          cfg_hi_we,
  input  logic          cmp_wr,
  input  logic [HW-1:0] wdata,
  output logic [CW-1:0] cfg_q
);
  localparam logic [HW-1:0] CAPS  = (HW'(1) << B_PCAP) | (HW'(1) << B_WCAP);
  localparam logic [HW-1:0] WMASK = (HW'(1) << B_EN) | (HW'(1) << B_PER) |
                                    (HW'(1) << B_SETV) | (HW'(1) << B_M32);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= {ROUTE_CAP, CAPS};
    end else if (cfg_lo_we) begin
      cfg_q[HW-1:0] <= (wdata & WMASK) | (cfg_q[HW-1:0] & ~WMASK);
    end else if (cmp_wr) begin
      cfg_q[B_SETV] <= 1'b0;
    end
  end

  // R6
  setv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !cfg_lo_we) |=> !cfg_q[B_SETV]);
  // R2
  hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hi_we && !cfg_lo_we && !cmp_wr) |=> $stable(cfg_q));
endmodule

// File: rtl/evtc_cmp.sv
module evtc_cmp
  import evtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m32,
  input  logic          per,
  input  logic          setv,
  input  logic          trunc,
  input  logic          kill,
  input  logic          cmp_lo_we,
  input  logic          cmp_hi_we,
  input  logic [HW-1:0] wdata,
  input  logic          hit,
  input  logic [CW-1:0] count_i,
  output logic [CW-1:0] cmp_q,
  output logic [CW-1:0] per_q,
  output logic          upd
);
  logic [CW-1:0] cmp_d, per_d, step;
  logic          chase_q, chase_d, adv_ok, ahead, direct;

  assign step   = step_f(cmp_q, per_q, m32);
  assign ahead  = ahead_f(cmp_q, count_i, m32);
  assign adv_ok = per && (per_q != '0);
  assign direct = !per || setv;

  always_comb begin
    cmp_d   = cmp_q;
    per_d   = per_q;
    chase_d = chase_q;
    if (trunc) begin
      cmp_d[CW-1:HW] = '0;
      per_d[CW-1:HW] = '0;
      chase_d        = 1'b0;
    end else if (cmp_lo_we) begin
      if (direct) cmp_d = m32 ? {{HW{1'b0}}, wdata} : {cmp_q[CW-1:HW], wdata};
      if (per)    per_d[HW-1:0] = m32 ? {1'b0, wdata[HW-2:0]} : wdata;
      chase_d = 1'b0;
    end else if (cmp_hi_we) begin
      if (direct) cmp_d[CW-1:HW] = m32 ? '0 : wdata;
      else        per_d[CW-1:HW] = m32 ? '0 : {1'b0, wdata[HW-2:0]};
      chase_d = 1'b0;
    end else if (hit && adv_ok) begin
      cmp_d   = step;
      chase_d = 1'b1;
    end else if (chase_q) begin
      if (!adv_ok || ahead) chase_d = 1'b0;
      else                  cmp_d   = step;
    end
    if (kill) chase_d = 1'b0;
  end

  assign upd = (cmp_d != cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '1;
      per_q   <= '0;
      chase_q <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      per_q   <= per_d;
      chase_q <= chase_d;
    end
  end

  // R5
  per_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we && per && m32 && !trunc) |=> !per_q[HW-1]);
  // R4
  oneshot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we && !per && !trunc) |=> (cmp_q[HW-1:0] == $past(wdata)));
  // R4
  periodic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we && per && !setv && !trunc) |=> $stable(cmp_q));
endmodule

// File: rtl/evtc_match.sv
module evtc_match
  import evtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          m32,
  input  logic          kill,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] cmp_q,
  input  logic          upd,
  output logic          hit,
  output logic          fire_q
);
  logic [CW-1:0] cnt_q;
  logic          seen_q, upd_q, eq, same, blocked;

  assign eq      = eq_f(count_i, cmp_q, m32);
  assign same    = (count_i == cnt_q) && !upd_q;
  assign blocked = seen_q && same;
  assign hit     = active && eq && !blocked && !kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      upd_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= count_i;
      upd_q  <= upd;
      seen_q <= hit || (blocked && eq && active);
      fire_q <= hit;
    end
  end

  // R10
  kill_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !fire_q);
  // R8
  held_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !upd) |=> !hit || (count_i != $past(count_i)));
endmodule

// File: rtl/evtc_channel.sv
module evtc_channel
  import evtc_pkg::*;
#(
  parameter logic [HW-1:0] ROUTE_CAP = 32'h0000_0F00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en_i,
  input  logic [CW-1:0] count_i,
  input  logic [HW-1:0] wdata_i,
  input  logic          cfg_lo_we_i,
  input  logic          cfg_hi_we_i,
  input  logic          cmp_lo_we_i,
  input  logic          cmp_hi_we_i,
  output logic          fire_o,
  output logic [CW-1:0] cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] period_o
);
  logic [CW-1:0] cfg_q, cmp_q, per_q;
  logic          cmp_wr, trunc, kill, active, hit, upd;

  assign cmp_wr = cmp_lo_we_i || cmp_hi_we_i;
  assign trunc  = cfg_lo_we_i && wdata_i[B_M32];
  assign kill   = cfg_lo_we_i && !wdata_i[B_EN];
  assign active = cfg_q[B_EN] && glb_en_i;

  evtc_cfg #(.ROUTE_CAP(ROUTE_CAP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_lo_we(cfg_lo_we_i), .cfg_hi_we(cfg_hi_we_i),
    .cmp_wr(cmp_wr), .wdata(wdata_i), .cfg_q(cfg_q));

  evtc_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .m32(cfg_q[B_M32]), .per(cfg_q[B_PER]),
    .setv(cfg_q[B_SETV]), .trunc(trunc), .kill(kill),
    .cmp_lo_we(cmp_lo_we_i), .cmp_hi_we(cmp_hi_we_i), .wdata(wdata_i),
    .hit(hit), .count_i(count_i), .cmp_q(cmp_q), .per_q(per_q), .upd(upd));

  evtc_match u_match (
    .clk(clk), .rst_n(rst_n), .active(active), .m32(cfg_q[B_M32]),
    .kill(kill), .count_i(count_i), .cmp_q(cmp_q), .upd(upd),
    .hit(hit), .fire_q(fire_o));

  assign cfg_o    = cfg_q;
  assign cmp_o    = cmp_q;
  assign period_o = per_q;

  // R3
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[B_M32] |-> (cmp_q[CW-1:HW] == '0) && (per_q[CW-1:HW] == '0));
  // R10
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |=> !fire_o);
endmodule

// File: tb/test_evtc_channel.sv
module test_evtc_channel;
  localparam logic [31:0] RC = 32'h00A5_0003;
  localparam int SEL_CFGLO = 0, SEL_CFGHI = 1, SEL_CMPLO = 2, SEL_CMPHI = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0;
  logic [63:0] count = '0;
  logic [31:0] wdata = '0;
  logic        cfg_lo_we = 1'b0, cfg_hi_we = 1'b0, cmp_lo_we = 1'b0, cmp_hi_we = 1'b0;
  logic        fire;
  logic [63:0] cfg, cmp, per;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  evtc_channel #(.ROUTE_CAP(RC)) i_evtc_channel (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en), .count_i(count),
    .wdata_i(wdata), .cfg_lo_we_i(cfg_lo_we), .cfg_hi_we_i(cfg_hi_we),
    .cmp_lo_we_i(cmp_lo_we), .cmp_hi_we_i(cmp_hi_we),
    .fire_o(fire), .cfg_o(cfg), .cmp_o(cmp), .period_o(per));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    wdata = d;
    cfg_lo_we = (sel == SEL_CFGLO);
    cfg_hi_we = (sel == SEL_CFGHI);
    cmp_lo_we = (sel == SEL_CMPLO);
    cmp_hi_we = (sel == SEL_CMPHI);
    @(negedge clk);
    {cfg_lo_we, cfg_hi_we, cmp_lo_we, cmp_hi_we} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; glb_en = 1'b0; count = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cfg", cfg, {RC, 32'h30});
    chk("R1 cmp", cmp, '1);
    chk("R1 period", per, '0);
    chk("R1 fire", {63'b0, fire}, 64'd0);
  endtask

  task automatic t_cfg_mask();
    do_reset();
    wr(SEL_CFGHI, 32'hFFFF_FFFF);
    chk("R2 upper write", cfg, {RC, 32'h30});
    wr(SEL_CFGLO, 32'hFFFF_FFFF);
    chk("R2 mask set", cfg, {RC, 32'h17C});
    chk("R7 cmp truncated", cmp, 64'h0000_0000_FFFF_FFFF);
    wr(SEL_CFGLO, 32'h0);
    chk("R2 caps kept", cfg, {RC, 32'h30});
  endtask

  task automatic t_periodic_write();
    do_reset();
    wr(SEL_CFGLO, 32'h8);
    wr(SEL_CMPLO, 32'h8000_0005);
    chk("R4 cmp kept", cmp, '1);
    chk("R5 period low", per, 64'h0000_0000_8000_0005);
    wr(SEL_CMPHI, 32'hFFFF_FFFF);
    chk("R5 period bit63", per, 64'h7FFF_FFFF_8000_0005);
    wr(SEL_CFGLO, 32'h48);
    chk("R6 arm set", {63'b0, cfg[6]}, 64'd1);
    wr(SEL_CMPLO, 32'h1234);
    chk("R4 armed load", cmp, 64'hFFFF_FFFF_0000_1234);
    chk("R6 arm cleared", {63'b0, cfg[6]}, 64'd0);
    wr(SEL_CMPHI, 32'h0);
    chk("R5 period hi", per, 64'h0000_0000_0000_1234);
    chk("R4 cmp kept hi", cmp, 64'hFFFF_FFFF_0000_1234);
  endtask

  task automatic t_narrow_write();
    do_reset();
    wr(SEL_CFGLO, 32'h108);
    wr(SEL_CMPLO, 32'hFFFF_FFFF);
    chk("R5 bit31 cleared", per, 64'h0000_0000_7FFF_FFFF);
    wr(SEL_CFGLO, 32'h100);
    wr(SEL_CMPHI, 32'hABCD);
    chk("R3 hi dropped", cmp, 64'h0000_0000_FFFF_FFFF);
    wr(SEL_CMPLO, 32'h1111);
    chk("R3 low load", cmp, 64'h0000_0000_0000_1111);
  endtask

  task automatic t_oneshot();
    do_reset();
    glb_en = 1'b1; count = 64'd50;
    wr(SEL_CMPLO, 32'd100);
    wr(SEL_CMPHI, 32'd0);
    wr(SEL_CFGLO, 32'h4);
    count = 64'd99; step(3);
    chk("R8 no early fire", {63'b0, fire}, 64'd0);
    count = 64'd100; step(1);
    chk("R8 fire", {63'b0, fire}, 64'd1);
    step(1);
    chk("R8 single pulse", {63'b0, fire}, 64'd0);
    step(2);
    chk("R8 held count", {63'b0, fire}, 64'd0);
    count = 64'd101; step(1);
    chk("R8 past", {63'b0, fire}, 64'd0);
    chk("R8 oneshot cmp", cmp, 64'd100);
  endtask

  task automatic t_advance();
    do_reset();
    glb_en = 1'b1;
    wr(SEL_CFGLO, 32'h48);
    wr(SEL_CMPHI, 32'h0);
    wr(SEL_CFGLO, 32'h48);
    wr(SEL_CMPLO, 32'd100);
    wr(SEL_CMPLO, 32'd3);
    chk("R9 setup cmp", cmp, 64'd100);
    chk("R9 setup period", per, 64'd3);
    wr(SEL_CFGLO, 32'hC);
    count = 64'd100; step(1);
    chk("R9 fire", {63'b0, fire}, 64'd1);
    chk("R9 first add", cmp, 64'd103);
    count = 64'd110; step(1);
    chk("R9 catch-up 1", cmp, 64'd106);
    chk("R9 no extra fire", {63'b0, fire}, 64'd0);
    step(1);
    chk("R9 catch-up 2", cmp, 64'd109);
    step(1);
    chk("R9 ahead", cmp, 64'd112);
    step(1);
    chk("R9 stops", cmp, 64'd112);
    chk("R9 quiet", {63'b0, fire}, 64'd0);
    count = 64'd112; step(1);
    chk("R9 next fire", {63'b0, fire}, 64'd1);
    chk("R9 next add", cmp, 64'd115);
  endtask

  task automatic t_wrap32();
    do_reset();
    glb_en = 1'b1;
    wr(SEL_CFGLO, 32'h148);
    wr(SEL_CMPLO, 32'hFFFF_FFF0);
    wr(SEL_CMPLO, 32'h20);
    chk("R9 wrap setup", cmp, 64'h0000_0000_FFFF_FFF0);
    wr(SEL_CFGLO, 32'h10C);
    count = 64'h0000_0005_FFFF_FFF0; step(1);
    chk("R9 narrow match", {63'b0, fire}, 64'd1);
    chk("R9 wrapped sum", cmp, 64'h0000_0000_0000_0010);
  endtask

  task automatic t_period0();
    do_reset();
    glb_en = 1'b1;
    wr(SEL_CFGLO, 32'h48);
    wr(SEL_CMPHI, 32'h0);
    wr(SEL_CFGLO, 32'h48);
    wr(SEL_CMPLO, 32'd40);
    wr(SEL_CMPLO, 32'd0);
    chk("R11 period zero", per, 64'd0);
    wr(SEL_CFGLO, 32'hC);
    count = 64'd40; step(1);
    chk("R11 fire", {63'b0, fire}, 64'd1);
    step(1);
    chk("R11 once", {63'b0, fire}, 64'd0);
    chk("R11 cmp kept", cmp, 64'd40);
  endtask

  task automatic t_disable();
    do_reset();
    glb_en = 1'b1;
    wr(SEL_CMPLO, 32'd60);
    wr(SEL_CMPHI, 32'd0);
    wr(SEL_CFGLO, 32'h4);
    count = 64'd60;
    wr(SEL_CFGLO, 32'h0);
    chk("R10 killed", {63'b0, fire}, 64'd0);
    step(1);
    chk("R10 stays off", {63'b0, fire}, 64'd0);
    chk("R10 cmp kept", cmp, 64'd60);
    glb_en = 1'b0;
    wr(SEL_CFGLO, 32'h4);
    step(2);
    chk("R10 global off", {63'b0, fire}, 64'd0);
    glb_en = 1'b1; step(1);
    chk("R8 fires on global on", {63'b0, fire}, 64'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cfg_mask();
    t_periodic_write();
    t_narrow_write();
    t_oneshot();
    t_advance();
    t_wrap32();
    t_period0();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule